// File: doc/BRIEF.md
# Timer Clock Select and Prescaler

This block decides, on every system-clock cycle, whether a timer/counter should advance. A 3-bit select input chooses the count source: none at all, the system clock itself, one of four power-of-two divisions of it (by 8, 64, 256 or 1024), or transitions of an external pin. In the external modes either falling or rising transitions are counted. The result is one output strobe that is high for a single system-clock cycle per count event. The counter that consumes the strobe sits outside the block.

The divided rates come from one free-running 10-bit prescaler counter that all taps share. A tap strobes in the last cycle of its period. A clear input restarts the prescaler, so software can align the first divided period to a known moment. The external pin passes through a two-flop synchroniser before edge detection. The pin is sampled whatever its direction elsewhere on the chip, so a pin the chip drives as an output can still step the timer under software control. The strobe leaves the block from a flip-flop.

Top module: `timer_clksel`

## Requirements
- R1: With select code 000 the strobe `cnt_en_o` stays low in every cycle. The strobe in a cycle depends on the select value sampled at the preceding clock edge.
- R2: With select code 001 the strobe is high in every cycle that follows an edge at which code 001 was sampled.
- R3: Select codes 010, 011, 100 and 101 produce strobes every 8, 64, 256 and 1024 cycles in that order. Each strobe is one cycle wide.
- R4: A prescaler clear sampled at an edge (call it edge 0) makes the first divided strobe for divisor N appear in the cycle after edge N. While the clear stays asserted, no divided strobe occurs from the cycle after edge 1 onward.
- R5: With select code 110, a falling transition of `ext_pin_i` made before edge 0 produces exactly one strobe, in the cycle after edge 2.
- R6: With select code 111, a rising transition of `ext_pin_i` made before edge 0 produces exactly one strobe, in the cycle after edge 2.
- R7: In the rising-edge mode a falling transition produces no strobe. In the falling-edge mode a rising transition produces no strobe.
- R8: The pin is sampled without any qualifying input. A train of transitions spaced three cycles apart yields exactly one strobe per transition of the selected polarity, and a pin that is steady produces no strobe.
- R9: While reset is asserted the strobe is low and the prescaler is at zero. With code 010 selected from reset release, the first strobe appears in the cycle after the 8th clock edge following release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Count source select code |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| presc_clr_i | input | 1 | Synchronous prescaler clear |
| cnt_en_o | output | 1 | Single-cycle count-enable strobe |

## Verification
Every divided code is started from a prescaler clear, and the strobe is compared cycle by cycle over three full periods. This separates a correct tap from a neighbouring tap, and a correct phase from a phase shifted by one cycle. The undivided code and the off code are each held for a stretch, which tells a constant-high enable from a constant-low one. The external modes are driven with isolated transitions of both polarities and with a regular toggle train. These patterns tell the right polarity from the wrong one, fixed synchroniser latency from drift, and one strobe per edge from double counting. Further cases cover a held clear and the phase after reset release, which show whether the prescaler starts from zero.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int unsigned SEL_W    = 3;
   localparam int unsigned NUM_TAPS = 4;
   localparam int unsigned MAX_TAP  = 10;

   typedef enum logic [SEL_W-1:0] {
      CS_OFF      = 3'd0,
      CS_DIV1     = 3'd1,
      CS_DIV8     = 3'd2,
      CS_DIV64    = 3'd3,
      CS_DIV256   = 3'd4,
      CS_DIV1024  = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } csel_e;

   // log2 of the divisor for each prescaler tap, lowest rate last
   function automatic int unsigned tap_shift(input int unsigned idx);
      case (idx)
         0:       return 3;
         1:       return 6;
         2:       return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
   parameter int unsigned PRESC_W  = 10,
   parameter int unsigned NUM_TAPS = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                clr_i,
   output logic [NUM_TAPS-1:0] tap_tick_o
);

   logic [PRESC_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PRESC_W'(1);
      end
   end

   // a tap fires in the final cycle of its period: low bits all ones
   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int unsigned SH = tcs_pkg::tap_shift(i);
      if (SH == 0 || SH > PRESC_W) begin : g_bad
         $error("tcs_prescaler: tap %0d needs %0d bits, counter has %0d", i, SH, PRESC_W);
         assign tap_tick_o[i] = 1'b0;
      end else begin : g_ok
         assign tap_tick_o[i] = &cnt_q[SH-1:0];
      end
   end

endmodule

// File: rtl/tcs_ext_sync.sv
module tcs_ext_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          IDLE   = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad
      $error("tcs_ext_sync: at least two synchroniser stages required, got %0d", STAGES);
   end

   // [STAGES-1] is the synchronised level, [STAGES] its previous value
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {(STAGES+1){IDLE}};
      end else begin
         chain_q <= {chain_q[STAGES-1:0], pin_i};
      end
   end

   assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/tcs_select.sv
module tcs_select #(
   parameter int unsigned NUM_TAPS = 4
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [tcs_pkg::SEL_W-1:0]   sel_i,
   input  logic [NUM_TAPS-1:0]         tap_tick_i,
   input  logic                        ext_rise_i,
   input  logic                        ext_fall_i,
   output logic                        en_o
);
   import tcs_pkg::*;

   if (NUM_TAPS != 4) begin : g_bad
      $error("tcs_select: code map covers exactly four taps, got %0d", NUM_TAPS);
   end

   logic en_d;

   always_comb begin
      unique case (csel_e'(sel_i))
         CS_OFF:      en_d = 1'b0;
         CS_DIV1:     en_d = 1'b1;
         CS_DIV8:     en_d = tap_tick_i[0];
         CS_DIV64:    en_d = tap_tick_i[1];
         CS_DIV256:   en_d = tap_tick_i[2];
         CS_DIV1024:  en_d = tap_tick_i[NUM_TAPS-1];
         CS_EXT_FALL: en_d = ext_fall_i;
         CS_EXT_RISE: en_d = ext_rise_i;
         default:     en_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o <= 1'b0;
      end else begin
         en_o <= en_d;
      end
   end

endmodule

// File: rtl/timer_clksel.sv
module timer_clksel #(
   parameter int unsigned PRESC_W     = tcs_pkg::MAX_TAP,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_IDLE    = 1'b0
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [tcs_pkg::SEL_W-1:0] sel_i,
   input  logic                      ext_pin_i,
   input  logic                      presc_clr_i,
   output logic                      cnt_en_o
);

   localparam int unsigned NUM_TAPS = tcs_pkg::NUM_TAPS;

   if (PRESC_W < tcs_pkg::MAX_TAP) begin : g_bad_w
      $error("timer_clksel: prescaler width %0d below slowest tap %0d", PRESC_W, tcs_pkg::MAX_TAP);
   end

   logic [NUM_TAPS-1:0] tap_tick;
   logic                ext_rise;
   logic                ext_fall;

   tcs_prescaler #(
      .PRESC_W  (PRESC_W),
      .NUM_TAPS (NUM_TAPS)
   ) u_presc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (presc_clr_i),
      .tap_tick_o (tap_tick)
   );

   tcs_ext_sync #(
      .STAGES (SYNC_STAGES),
      .IDLE   (PIN_IDLE)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_pin_i),
      .rise_o (ext_rise),
      .fall_o (ext_fall)
   );

   tcs_select #(
      .NUM_TAPS (NUM_TAPS)
   ) u_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel_i),
      .tap_tick_i (tap_tick),
      .ext_rise_i (ext_rise),
      .ext_fall_i (ext_fall),
      .en_o       (cnt_en_o)
   );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] sel_i,
   input logic       ext_pin_i,
   input logic       presc_clr_i,
   input logic       cnt_en_o
);

   logic [2:0] prev_sel_q;
   logic       clr_d_q;
   logic       pin_d1_q, pin_d2_q, pin_d3_q;
   logic [1:0] age_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_sel_q <= 3'd0;
         clr_d_q    <= 1'b0;
         pin_d1_q   <= 1'b0;
         pin_d2_q   <= 1'b0;
         pin_d3_q   <= 1'b0;
         age_q      <= 2'd0;
      end else begin
         prev_sel_q <= sel_i;
         clr_d_q    <= presc_clr_i;
         pin_d1_q   <= ext_pin_i;
         pin_d2_q   <= pin_d1_q;
         pin_d3_q   <= pin_d2_q;
         if (age_q != 2'd3) age_q <= age_q + 2'd1;
      end
   end

   logic div_code;
   assign div_code = (sel_i >= 3'd2) && (sel_i <= 3'd5);

   p_off_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'd0) |=> !cnt_en_o);

   p_div1_every_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'd1) |=> cnt_en_o);

   p_div_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q != 2'd0 && cnt_en_o && div_code && sel_i == prev_sel_q) |=> !cnt_en_o);

   p_clr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q != 2'd0 && clr_d_q && presc_clr_i && div_code) |=> !cnt_en_o);

   p_ext_needs_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 && sel_i >= 3'd6 && pin_d2_q == pin_d3_q) |=> !cnt_en_o);

   always_comb begin
      if (!rst_ni) begin
         p_reset_low_r9: assert (!cnt_en_o);
      end
   end

endmodule

bind timer_clksel tcs_checker u_chk (.*);

// File: tb/timer_clksel_tb.sv
`timescale 1ns/1ps
module timer_clksel_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       pin = 1'b0;
   logic       clr = 1'b0;
   logic       en;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   timer_clksel u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sel_i       (sel),
      .ext_pin_i   (pin),
      .presc_clr_i (clr),
      .cnt_en_o    (en)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_phase();
      int first;
      chk("R9", "strobe during reset", int'(en), 0);
      @(negedge clk);
      rst_n = 1'b1;
      sel   = 3'd2;
      first = -1;
      for (int k = 1; k <= 20; k++) begin
         step();
         if (en && first < 0) first = k;
      end
      chk("R9", "first div8 strobe edge after release", first, 8);
   endtask

   task automatic t_off();
      int hits;
      sel = 3'd0;
      step();
      hits = 0;
      for (int k = 0; k < 40; k++) begin
         step();
         if (en) hits++;
      end
      chk("R1", "strobes with code 000", hits, 0);
   endtask

   task automatic t_div1();
      int hits;
      sel = 3'd1;
      step();
      hits = 0;
      for (int k = 0; k < 20; k++) begin
         step();
         if (en) hits++;
      end
      chk("R2", "strobes in 20 cycles with code 001", hits, 20);
   endtask

   task automatic t_div(input logic [2:0] code, input int n);
      int hits, wrong;
      sel = code;
      clr = 1'b1;
      step();
      clr = 1'b0;
      hits  = 0;
      wrong = 0;
      for (int k = 1; k <= 3*n + 1; k++) begin
         step();
         if (en) hits++;
         if (int'(en) != int'((k % n) == 0)) wrong++;
      end
      chk("R3", $sformatf("strobe count for divide %0d", n), hits, 3);
      chk("R4", $sformatf("misplaced strobes after clear, divide %0d", n), wrong, 0);
   endtask

   task automatic t_clr_hold();
      int hits;
      sel = 3'd3;
      clr = 1'b1;
      step();
      hits = 0;
      for (int k = 0; k < 1100; k++) begin
         step();
         if (en) hits++;
      end
      clr = 1'b0;
      chk("R4", "strobes while clear held", hits, 0);
   endtask

   task automatic settle(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   // change the pin and expect a strobe only after the third edge (or none)
   task automatic ext_edge(input string req, input logic lvl, input bit expect_hit);
      int wrong;
      pin   = lvl;
      wrong = 0;
      for (int k = 1; k <= 6; k++) begin
         step();
         if (int'(en) != int'(expect_hit && k == 3)) wrong++;
      end
      chk(req, $sformatf("strobe timing, pin to %0d, sel %0d", lvl, sel), wrong, 0);
   endtask

   task automatic t_ext_single();
      sel = 3'd7;
      pin = 1'b0;
      settle(5);
      ext_edge("R6", 1'b1, 1'b1);
      ext_edge("R7", 1'b0, 1'b0);
      sel = 3'd6;
      settle(5);
      ext_edge("R7", 1'b1, 1'b0);
      ext_edge("R5", 1'b0, 1'b1);
   endtask

   task automatic t_ext_train(input logic [2:0] code);
      int hits;
      sel = code;
      pin = 1'b0;
      settle(5);
      hits = 0;
      for (int t = 0; t < 20; t++) begin
         pin = ~pin;
         for (int k = 0; k < 3; k++) begin
            step();
            if (en) hits++;
         end
      end
      for (int k = 0; k < 6; k++) begin
         step();
         if (en) hits++;
      end
      chk("R8", $sformatf("strobes for 20-toggle train, sel %0d", code), hits, 10);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #25;
      t_reset_phase();
      t_off();
      t_div1();
      t_div(3'd2, 8);
      t_div(3'd3, 64);
      t_div(3'd4, 256);
      t_div(3'd5, 1024);
      t_clr_hold();
      t_ext_single();
      t_ext_train(3'd7);
      t_ext_train(3'd6);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule